// File: doc/BRIEF.md
# System Controller Register Bank

This block is a small memory-mapped control peripheral that sits on a 32-bit word-addressed register port. It groups several independent services behind sixteen word addresses:
- a general-purpose input bank, sampled from pins through a two-flop synchronizer, with a per-bit change interrupt;
- a general-purpose output bank that drives pins;
- two up-counting compare timers, each with its own interrupt line;
- a configuration-port command word;
- a read-only capabilities word;
- a system identification word.

Two writes act as commands rather than as storage. Writing the command code 0x000E in the low half of the configuration-port word requests a shutdown. Any write to the identification word requests a system reset. Each request appears as a one-cycle strobe. The logic that acts on these strobes lives outside the block.

The register port accepts one access in every cycle and never applies back-pressure. A read is requested with `bus_en` high and `bus_we` low. Its data appears on `bus_rdata` in the following cycle, with `bus_rvalid` high. A write takes effect at the clock edge on which it is presented.

Top module: `sysctl_top`

## Requirements
- R1: After reset these words read as follows: word 15 = 0x10014D31, word 14 = 0, word 13 = 0x00000001 (ready bit 0), words 1, 2, 4, 5, 6, 8, 9 and 10 = 0. Word 0 reads the synchronized pins, and its flops reset to the strap value 0x01.
- R2: A read presented at one clock edge returns data on `bus_rdata`, with `bus_rvalid` high, after that edge and for exactly one cycle.
- R3: Words 3, 7, 11 and 12 read as zero. Writes to them change no readable state.
- R4: Word 0 (pin input) and word 14 (capabilities) ignore writes.
- R5: Word 1 stores the low GPIO_W bits of the write data, drives `gpio_out` and reads back. Word 2 holds the change-interrupt enable mask.
- R6: `irq_gpio` pulses for one cycle when a synchronized input bit whose mask bit is set changes value. Changes on masked-off bits raise nothing.
- R7: A timer's control word has bit 0 = run and bit 1 = auto-restart. While running, the counter word increments once per cycle. Words 4/5/6 are timer 0 control/compare/counter and words 8/9/10 are timer 1 control/compare/counter. Counter and compare are writable, and a counter read returns the live count.
- R8: When a running counter is greater than or equal to its compare value, the counter returns to 0 and the timer's interrupt pulses for one cycle.
- R9: At a hit without auto-restart, the run bit clears and the timer stops. With auto-restart set, the timer keeps running.
- R10: A write to word 13 whose low 16 bits equal 0x000E pulses `shutdown_req` for one cycle after the write edge. Other values produce no pulse.
- R11: Any write to word 15 pulses `reset_req` for one cycle after the write edge. The identification word keeps its value.
- R12: `irq_timer0` and `irq_timer1` are driven only by their own timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| gpio_in | input | GPIO_W | Input pins (asynchronous) |
| gpio_out | output | GPIO_W | Output pins |
| irq_gpio | output | 1 | Input change interrupt pulse |
| irq_timer0 | output | 1 | Timer 0 hit pulse |
| irq_timer1 | output | 1 | Timer 1 hit pulse |
| shutdown_req | output | 1 | Shutdown request strobe |
| reset_req | output | 1 | System reset request strobe |

## Verification
The assertions watch several behaviours on every cycle:
- read data arrives exactly one cycle after the request, and reserved words return zero;
- the command strobes last a single cycle and follow the writes that cause them;
- a timer interrupt only comes from a running timer and always leaves the counter at zero;
- at a hit, the run bit behaves as the auto-restart setting says.

Only the bench scenarios can show the rest:
- the exact reset values;
- that writes to read-only and reserved words leave no trace;
- that masked input changes stay silent;
- that the live count equals the number of running cycles;
- that one timer's activity never reaches the other timer's interrupt.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_GPIN   = 4'd0;
  localparam logic [AW-1:0] A_GPOUT  = 4'd1;
  localparam logic [AW-1:0] A_GPMASK = 4'd2;
  localparam logic [AW-1:0] A_T0BASE = 4'd4;
  localparam logic [AW-1:0] A_T1BASE = 4'd8;
  localparam logic [AW-1:0] A_CFGCMD = 4'd13;
  localparam logic [AW-1:0] A_CAPS   = 4'd14;
  localparam logic [AW-1:0] A_IDENT  = 4'd15;
  localparam int NTIMER = 2;
  typedef struct packed {
    logic autorun;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/sysctl_gpio.sv
module sysctl_gpio #(
  parameter int W = 8,
  parameter logic [W-1:0] STRAP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] sync_o,
  output logic         irq_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= STRAP;
      s2_q   <= STRAP;
      prev_q <= STRAP;
      irq_o  <= 1'b0;
    end else begin
      s1_q   <= pins_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      irq_o  <= |((s2_q ^ prev_q) & mask_i);
    end
  end

  assign sync_o = s2_q;

  // R6: an interrupt needs at least one enabled bit in the previous cycle
  p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|mask_i));
endmodule

// File: rtl/sysctl_timer.sv
module sysctl_timer #(
  parameter int TW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ctrl,
  input  logic                  wr_cmp,
  input  logic                  wr_cnt,
  input  sysctl_pkg::tmr_ctrl_t ctrl_d,
  input  logic [TW-1:0]         wdata,
  output sysctl_pkg::tmr_ctrl_t ctrl_q,
  output logic [TW-1:0]         cmp_q,
  output logic [TW-1:0]         cnt_q,
  output logic                  irq_o
);
  logic tick;
  assign tick = ctrl_q.run && !wr_ctrl && !wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      cnt_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_cmp)  cmp_q  <= wdata;
      if (wr_cnt)  cnt_q  <= wdata;
      if (tick) begin
        if (cnt_q >= cmp_q) begin
          cnt_q <= '0;
          irq_o <= 1'b1;
          if (!ctrl_q.autorun) ctrl_q.run <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_irq_from_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(ctrl_q.run));
  p_hit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cnt_q == '0);
  p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !$past(ctrl_q.autorun)) |-> !ctrl_q.run);
  p_autorestart_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && $past(ctrl_q.autorun)) |-> ctrl_q.run);
endmodule

// File: rtl/sysctl_top.sv
module sysctl_top
  import sysctl_pkg::*;
#(
  parameter int GPIO_W = 8,
  parameter logic [GPIO_W-1:0] STRAP = 8'h01,
  parameter logic [31:0] SYS_ID = 32'h10014D31,
  parameter logic [31:0] CAPS = 32'h0,
  parameter logic [15:0] SHUTDOWN_CODE = 16'h000E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [GPIO_W-1:0] gpio_in,
  output logic [GPIO_W-1:0] gpio_out,
  output logic              irq_gpio,
  output logic              irq_timer0,
  output logic              irq_timer1,
  output logic              shutdown_req,
  output logic              reset_req
);
  localparam logic [31:0] CFG_READY = 32'h1;

  logic              wr, rd;
  logic [GPIO_W-1:0] mask_q, gpin;
  tmr_ctrl_t         t_ctrl [NTIMER];
  logic [DW-1:0]     t_cmp  [NTIMER];
  logic [DW-1:0]     t_cnt  [NTIMER];
  logic [NTIMER-1:0] t_irq;

  assign wr = bus_en && bus_we;
  assign rd = bus_en && !bus_we;

  sysctl_gpio #(.W(GPIO_W), .STRAP(STRAP)) u_gpio (
    .clk(clk), .rst_n(rst_n), .pins_i(gpio_in), .mask_i(mask_q),
    .sync_o(gpin), .irq_o(irq_gpio));

  for (genvar t = 0; t < NTIMER; t++) begin : g_tmr
    localparam logic [3:0] BASE = (t == 0) ? A_T0BASE : A_T1BASE;
    sysctl_timer #(.TW(DW)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(wr && bus_addr == BASE),
      .wr_cmp (wr && bus_addr == BASE + 4'd1),
      .wr_cnt (wr && bus_addr == BASE + 4'd2),
      .ctrl_d (tmr_ctrl_t'(bus_wdata[1:0])),
      .wdata  (bus_wdata),
      .ctrl_q (t_ctrl[t]), .cmp_q(t_cmp[t]), .cnt_q(t_cnt[t]),
      .irq_o  (t_irq[t]));
  end

  assign irq_timer0 = t_irq[0];
  assign irq_timer1 = t_irq[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpio_out     <= '0;
      mask_q       <= '0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
    end else begin
      shutdown_req <= wr && bus_addr == A_CFGCMD && bus_wdata[15:0] == SHUTDOWN_CODE;
      reset_req    <= wr && bus_addr == A_IDENT;
      if (wr && bus_addr == A_GPOUT)  gpio_out <= bus_wdata[GPIO_W-1:0];
      if (wr && bus_addr == A_GPMASK) mask_q   <= bus_wdata[GPIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) begin
        case (bus_addr)
          A_GPIN:          bus_rdata <= DW'(gpin);
          A_GPOUT:         bus_rdata <= DW'(gpio_out);
          A_GPMASK:        bus_rdata <= DW'(mask_q);
          A_T0BASE:        bus_rdata <= DW'(t_ctrl[0]);
          A_T0BASE + 4'd1: bus_rdata <= t_cmp[0];
          A_T0BASE + 4'd2: bus_rdata <= t_cnt[0];
          A_T1BASE:        bus_rdata <= DW'(t_ctrl[1]);
          A_T1BASE + 4'd1: bus_rdata <= t_cmp[1];
          A_T1BASE + 4'd2: bus_rdata <= t_cnt[1];
          A_CFGCMD:        bus_rdata <= CFG_READY;
          A_CAPS:          bus_rdata <= CAPS;
          A_IDENT:         bus_rdata <= SYS_ID;
          default:         bus_rdata <= '0;
        endcase
      end
    end
  end

  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);
  p_rvalid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !bus_rvalid);
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (bus_addr == 4'd3 || bus_addr == 4'd7 || bus_addr == 4'd11 || bus_addr == 4'd12))
      |=> bus_rdata == '0);
  p_shutdown_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req || $past(wr && bus_addr == A_CFGCMD, 1));
  p_reset_on_ident_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_IDENT) |=> reset_req);
  p_ident_const_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == A_IDENT) |=> bus_rdata == SYS_ID);
endmodule

// File: tb/sim_sysctl_top.sv
module sim_sysctl_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_we = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [7:0] gpio_in = 8'h01, gpio_out;
  logic irq_gpio, irq_timer0, irq_timer1, shutdown_req, reset_req;
  int checks = 0, errors = 0;
  int n_t0 = 0, n_t1 = 0, n_g = 0;
  logic wr_sd, wr_rr;

  always #2.5 clk = ~clk;

  sysctl_top u0 (.*);

  always @(negedge clk) begin
    n_t0 <= n_t0 + int'(irq_timer0);
    n_t1 <= n_t1 + int'(irq_timer1);
    n_g  <= n_g + int'(irq_gpio);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    wr_sd = shutdown_req; wr_rr = reset_req;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    chk("R2 rvalid", 32'(bus_rvalid), 32'd1);
    bus_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam int NV = 16;
  localparam logic       V_WE   [NV] = '{0,0,0,0, 1,0, 1,0, 1,0, 1,0, 1,0, 1,0};
  localparam logic [3:0] V_ADDR [NV] = '{14,15,13,0, 1,1, 3,3, 12,12, 14,14, 0,0, 9,9};
  localparam logic [31:0] V_DATA [NV] = '{0,0,0,0, 32'hA5,0, 32'hFFFFFFFF,0, 32'h1234,0,
                                          32'hDEAD,0, 32'hFF,0, 32'h64,0};
  // R1 reset words, R5 output readback, R3 reserved, R4 read-only, R7 compare
  localparam logic [31:0] V_EXP  [NV] = '{0,32'h10014D31,1,1, 0,32'hA5, 0,0, 0,0,
                                          0,0, 0,1, 0,32'h64};

  task automatic finish_up;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    int b0, b1, bg;
    idle(3);
    chk("R1 gpio_out reset", 32'(gpio_out), 0);
    chk("R1 strobes reset", {30'd0, shutdown_req, reset_req}, 0);
    rst_n = 1;
    idle(2);
    for (int i = 0; i < NV; i++) begin
      if (V_WE[i]) wr(V_ADDR[i], V_DATA[i]);
      else begin
        rd(V_ADDR[i], d);
        chk($sformatf("R%0d vec%0d", (i < 4) ? 1 : 3, i), d, V_EXP[i]);
      end
    end
    chk("R5 gpio_out pins", 32'(gpio_out), 32'hA5);
    rd(4'd2, d); chk("R1 mask reset", d, 0);
    rd(4'd6, d); chk("R1 t0 counter reset", d, 0);
    idle(1);
    chk("R2 rvalid drops", 32'(bus_rvalid), 0);

    // R6 masked change silent, enabled change pulses once
    wr(4'd2, 32'h02);
    bg = n_g; gpio_in = 8'h05; idle(8);
    chk("R6 masked change", n_g - bg, 0);
    bg = n_g; gpio_in = 8'h07; idle(8);
    chk("R6 enabled change", n_g - bg, 1);
    rd(4'd0, d); chk("R6 synced input", d, 32'h07);

    // R7 live count equals run cycles
    wr(4'd5, 32'd1000); wr(4'd6, 0);
    wr(4'd4, 32'h1); idle(17); wr(4'd4, 32'h0);
    rd(4'd6, d); chk("R7 live count", d, 32'd17);

    // R8 R9 R12 one-shot timer 0
    b0 = n_t0; b1 = n_t1;
    wr(4'd5, 32'd5); wr(4'd6, 0); wr(4'd4, 32'h1); idle(20);
    chk("R8 one hit", n_t0 - b0, 1);
    chk("R12 timer1 quiet", n_t1 - b1, 0);
    rd(4'd4, d); chk("R9 run cleared", d, 0);
    rd(4'd6, d); chk("R8 counter zero", d, 0);

    // R9 auto-restart on timer 1, period compare+1
    b0 = n_t0; b1 = n_t1;
    wr(4'd9, 32'd3); wr(4'd8, 32'h3); idle(40);
    rd(4'd8, d); chk("R9 still running", d, 32'h3);
    wr(4'd8, 0);
    chk("R9 restart count", 32'(n_t1 - b1 >= 9 && n_t1 - b1 <= 11), 1);
    chk("R12 timer0 quiet", n_t0 - b0, 0);

    // R10 shutdown command
    wr(4'd13, 32'h1234000E); chk("R10 shutdown pulse", 32'(wr_sd), 1);
    idle(1); chk("R10 single cycle", 32'(shutdown_req), 0);
    wr(4'd13, 32'h0000000F); chk("R10 other code", 32'(wr_sd), 0);
    rd(4'd13, d); chk("R10 ready kept", d, 1);

    // R11 identification write
    wr(4'd15, 32'h0); chk("R11 reset pulse", 32'(wr_rr), 1);
    idle(1); chk("R11 single cycle", 32'(reset_req), 0);
    rd(4'd15, d); chk("R11 id unchanged", d, 32'h10014D31);
    finish_up();
  end
endmodule